// File: doc/BRIEF.md
# Radix-4 Digit-Reversal Reorder Buffer

This block sits behind a 1024-point radix-4 FFT. It takes the complex results in the order the transform produces them and hands them on in natural index order. Each result is an I/Q pair of 14-bit signed words. The transform emits them with the five base-4 digits of the index in reversed order.

Two storage banks work in alternation. While the write side fills one bank with an arriving frame, the read side drains the other. The write address is the arrival count with its 2-bit digits swapped end for end. The read address is a plain counter. Readout of a frame begins as soon as its last sample is stored, and it runs at one sample per clock. The input may pause at any time by holding its valid strobe low. Because the read side is at least as fast as the write side, a continuous input stream gives a continuous output stream with no dropped frames.

Top module: `dr4_reorder`

## Requirements
- R1: While `rst_n` is low at a rising edge, the counters, the bank selector and `out_valid` are cleared. `out_valid` stays low after reset until a complete frame has been received.
- R2: A sample is taken only in a cycle where `in_valid` is high. Cycles with `in_valid` low do not advance the frame, whatever `in_i`/`in_q` carry at the time.
- R3: Define digit k of the arrival position p (counted from 0 within the frame) as bits p[2k+1:2k], for k = 0..4. The sample at position p carries the natural index whose digit k equals digit 4-k of p. Each digit keeps its own two bits.
- R4: Each frame leaves on 1024 consecutive cycles with `out_valid` high, with indices 0, 1, ..., 1023 in that order. I and Q are carried unchanged.
- R5: `out_valid` rises, carrying index 0, at the first rising edge after the edge that accepts a frame's 1024th sample.
- R6: Samples of the next frame may arrive while a frame is being read out, and they do not disturb that readout.
- R7: A frame may complete in the same cycle that the last read of the previous frame is issued. Its readout then follows with no idle cycle between the two frames.
- R8: An incomplete frame produces no output. `out_valid` is low whenever no complete frame is being emitted.
- R9: A reset in the middle of a frame discards the partial frame. The next accepted sample is position 0 of a new frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; everything is updated on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Marks a cycle carrying an input sample |
| in_i | input | 14 | In-phase part of the input sample, signed |
| in_q | input | 14 | Quadrature part of the input sample, signed |
| out_valid | output | 1 | Marks a cycle carrying an output sample |
| out_i | output | 14 | In-phase part of the output sample, signed |
| out_q | output | 14 | Quadrature part of the output sample, signed |

## Verification
Two things can happen in the same cycle: a frame finishing on the write side, and the read side issuing the final address of the previous frame. The bench provokes this by streaming three frames with `in_valid` held high throughout. Each completion then lands exactly on the previous frame's last read. The result is judged by `out_valid` staying high across each frame boundary, by index 0 of the new frame following index 1023 of the old one, and by each new frame starting exactly one edge after its final sample is accepted. Frames with random gaps, some of them overlapping a readout, cover the case where the two events are apart.

// File: rtl/dr4_pkg.sv
`timescale 1ns/1ps
// Package: shared defaults and types for the digit-reversal reorder buffer.
// Assumes nothing beyond IEEE 1800-2017 packages.
package dr4_pkg;

    // Default number of base-4 digits per index (4**5 = 1024 points).
    parameter int DIGITS_DEFAULT   = 5;
    // Default width of each of the I and Q words.
    parameter int SAMPLE_W_DEFAULT = 14;

    // Read-side sequencing state.
    typedef enum logic {
        RD_IDLE = 1'b0,
        RD_RUN  = 1'b1
    } rd_state_e;

endpackage

// File: rtl/dr4_write_ctrl.sv
`timescale 1ns/1ps
// Module: dr4_write_ctrl
// Counts accepted samples within a frame and turns each arrival position
// into a storage address by reversing the order of its base-4 digits.
// Flags the cycle that carries the last sample of a frame and swaps the
// bank being filled at that edge.
// Assumes: frames are exactly 4**DIGITS samples; a sample is present only
// when in_valid is high.
module dr4_write_ctrl #(
    parameter int DIGITS = 5,
    localparam int AW    = 2 * DIGITS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic          wr_bank,
    output logic          frame_done,
    output logic          done_bank
);

    logic [AW-1:0] pos_cnt;
    logic          fill_bank;

    // Swap the digit pairs of the arrival position to form the address.
    for (genvar k = 0; k < DIGITS; k++) begin : g_digit
        assign wr_addr[2*k+1 -: 2] = pos_cnt[2*(DIGITS-1-k)+1 -: 2];
    end

    // Write strobe and frame-end detection for the current sample.
    always_comb begin
        wr_en      = in_valid;
        frame_done = in_valid && (pos_cnt == '1);
        wr_bank    = fill_bank;
        done_bank  = fill_bank;
    end

    // Position counter and bank selector; the counter wraps at frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_cnt   <= '0;
            fill_bank <= 1'b0;
        end else if (in_valid) begin
            pos_cnt <= pos_cnt + 1'b1;
            if (pos_cnt == '1) begin
                fill_bank <= ~fill_bank;
            end
        end
    end

    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(pos_cnt))
        else $error("position advanced without a valid sample"); // R2

endmodule

// File: rtl/dr4_bank_pair.sv
`timescale 1ns/1ps
// Module: dr4_bank_pair
// Two equal storage banks with one write port and one registered read
// port each. The write goes to the bank named by wr_bank and the read comes
// from the bank named by rd_bank. Read data appears one clock after the read.
// Assumes: the caller never reads and writes the same bank in one cycle.
module dr4_bank_pair #(
    parameter int AW    = 10,
    parameter int WORDW = 28,
    localparam int DEPTH = 1 << AW
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic             wr_bank,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WORDW-1:0] wr_data,
    input  logic             rd_en,
    input  logic             rd_bank,
    input  logic [AW-1:0]    rd_addr,
    output logic [WORDW-1:0] rd_data
);

    logic [WORDW-1:0] bank_q [2];
    logic             sel_q;

    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic [WORDW-1:0] store [DEPTH];

        // Write port and registered read port of this bank.
        always_ff @(posedge clk) begin
            if (wr_en && (wr_bank == 1'(b))) begin
                store[wr_addr] <= wr_data;
            end
            if (rd_en && (rd_bank == 1'(b))) begin
                bank_q[b] <= store[rd_addr];
            end
        end
    end

    // Remember which bank the pending read came from.
    always_ff @(posedge clk) begin
        if (rd_en) begin
            sel_q <= rd_bank;
        end
    end

    // Select the bank that delivered the last read.
    always_comb begin
        rd_data = sel_q ? bank_q[1] : bank_q[0];
    end

endmodule

// File: rtl/dr4_read_ctrl.sv
`timescale 1ns/1ps
// Module: dr4_read_ctrl
// Drains a completed bank in natural order, one address per clock, and
// produces an output strobe that lines up with the one-cycle read latency.
// A frame completing on the last read of the previous frame starts at once.
// Assumes: writes arrive at most one per clock, so a completion can never
// land while more than one read of the previous frame is outstanding.
module dr4_read_ctrl
    import dr4_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_done,
    input  logic          done_bank,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    output logic          rd_bank,
    output logic          out_valid
);

    rd_state_e     state;
    logic [AW-1:0] rd_cnt;
    logic          drain_bank;
    logic          last_rd;
    logic          busy;

    // Read strobe, address and the end-of-drain condition.
    always_comb begin
        rd_en   = (state == RD_RUN);
        rd_addr = rd_cnt;
        rd_bank = drain_bank;
        last_rd = (state == RD_RUN) && (rd_cnt == '1);
        busy    = (state == RD_RUN) && !last_rd;
    end

    // Sequence reads and delay the strobe to match the storage latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= RD_IDLE;
            rd_cnt     <= '0;
            drain_bank <= 1'b0;
            out_valid  <= 1'b0;
        end else begin
            out_valid <= (state == RD_RUN);
            if (frame_done) begin
                state      <= RD_RUN;
                rd_cnt     <= '0;
                drain_bank <= done_bank;
            end else if (state == RD_RUN) begin
                rd_cnt <= rd_cnt + 1'b1;
                if (last_rd) begin
                    state <= RD_IDLE;
                end
            end
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !out_valid)
        else $error("output strobe high after reset"); // R1

    AST_READ_START: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> (rd_en && rd_addr == '0))
        else $error("drain did not start at index 0"); // R5

    AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> !busy)
        else $error("frame completed during an unfinished drain"); // R7

endmodule

// File: rtl/dr4_reorder.sv
`timescale 1ns/1ps
// Module: dr4_reorder (top)
// Reorders radix-4 transform results from digit-reversed to natural index
// order with two alternating banks: one fills while the other drains.
// Assumes: frames of 4**DIGITS samples, I/Q words of SAMPLE_W bits each.
module dr4_reorder
    import dr4_pkg::*;
#(
    parameter int DIGITS   = DIGITS_DEFAULT,
    parameter int SAMPLE_W = SAMPLE_W_DEFAULT,
    localparam int AW      = 2 * DIGITS,
    localparam int WORDW   = 2 * SAMPLE_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic signed [SAMPLE_W-1:0] in_i,
    input  logic signed [SAMPLE_W-1:0] in_q,
    output logic                       out_valid,
    output logic signed [SAMPLE_W-1:0] out_i,
    output logic signed [SAMPLE_W-1:0] out_q
);

    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic          wr_bank;
    logic          frame_done;
    logic          done_bank;
    logic          rd_en;
    logic [AW-1:0] rd_addr;
    logic          rd_bank;
    logic [WORDW-1:0] rd_data;

    dr4_write_ctrl #(.DIGITS(DIGITS)) u_wr (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_bank    (wr_bank),
        .frame_done (frame_done),
        .done_bank  (done_bank)
    );

    dr4_bank_pair #(.AW(AW), .WORDW(WORDW)) u_mem (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_bank (wr_bank),
        .wr_addr (wr_addr),
        .wr_data ({in_i, in_q}),
        .rd_en   (rd_en),
        .rd_bank (rd_bank),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    dr4_read_ctrl #(.AW(AW)) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_done (frame_done),
        .done_bank  (done_bank),
        .rd_en      (rd_en),
        .rd_addr    (rd_addr),
        .rd_bank    (rd_bank),
        .out_valid  (out_valid)
    );

    // Split the stored word back into its I and Q halves.
    always_comb begin
        out_i = rd_data[WORDW-1 -: SAMPLE_W];
        out_q = rd_data[SAMPLE_W-1:0];
    end

    AST_BANK_APART: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (rd_bank != wr_bank))
        else $error("drain and fill aimed at the same bank"); // R6

    AST_FIRST_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> ($past(rd_addr) == '0))
        else $error("output burst did not begin at index 0"); // R4

endmodule

// File: tb/dr4_reorder_bench.sv
`timescale 1ns/1ps
module dr4_reorder_bench;

    localparam int DIG = 5;
    localparam int NPT = 1 << (2 * DIG);

    logic              clk = 1'b0;
    logic              rst_n;
    logic              in_valid;
    logic signed [13:0] in_i;
    logic signed [13:0] in_q;
    logic              out_valid;
    logic signed [13:0] out_i;
    logic signed [13:0] out_q;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int done_frames = 0;
    int fr_out = 0;
    int idx = 0;
    int bb_seen = 0;
    bit prev_valid = 1'b0;
    int last_edge [8];

    dr4_reorder u_dr4_reorder (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_i      (in_i),
        .in_q      (in_q),
        .out_valid (out_valid),
        .out_i     (out_i),
        .out_q     (out_q)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc++;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Natural index carried by arrival position p: digit order reversed.
    function automatic int nat_of(input int p);
        int r = 0;
        for (int k = 0; k < DIG; k++) begin
            r = r | (((p >> (2 * k)) & 3) << (2 * (DIG - 1 - k)));
        end
        return r;
    endfunction

    function automatic logic [13:0] exp_i(input int f, input int n);
        return {4'(f), 10'(n)};
    endfunction

    function automatic logic [13:0] exp_q(input int f, input int n);
        return {10'(n), 4'(f)} ^ 14'h2AAA;
    endfunction

    task automatic idle_cycle();
        in_valid = 1'b0;
        in_i = 14'($urandom);
        in_q = 14'($urandom);
        @(negedge clk);
    endtask

    // Send positions [0, count) of frame f, with random idle cycles.
    task automatic send(input int f, input int count, input int gap_pct, input bit pause_last);
        for (int p = 0; p < count; p++) begin
            while ($urandom_range(99) < gap_pct) idle_cycle();
            if (pause_last && p == NPT - 1) begin
                repeat (30) idle_cycle();
                chk(out_valid == 1'b0, "R2 pause before last", int'(out_valid), 0);
            end
            in_valid = 1'b1;
            in_i = exp_i(f, nat_of(p));
            in_q = exp_q(f, nat_of(p));
            if (p == NPT - 1) begin
                last_edge[f] = cyc + 1;
                done_frames++;
            end
            @(negedge clk);
        end
    endtask

    // Output monitor: order, data, latency, contiguity and stray output.
    always @(negedge clk) begin
        if (out_valid) begin
            if (fr_out >= done_frames) begin
                chk(1'b0, "R8 output without complete frame", fr_out, done_frames);
            end else begin
                chk(out_i == exp_i(fr_out, idx) && out_q == exp_q(fr_out, idx),
                    "R3/R4/R9 data", int'(out_i), int'(exp_i(fr_out, idx)));
                if (idx == 0) begin
                    chk(cyc == last_edge[fr_out] + 1, "R5 start latency", cyc, last_edge[fr_out] + 1);
                    if (prev_valid) bb_seen++;
                end
                idx++;
                if (idx == NPT) begin
                    idx = 0;
                    fr_out++;
                end
            end
        end else if (idx != 0) begin
            chk(1'b0, "R4 gap inside frame", idx, 0);
            idx = 0;
            fr_out++;
        end
        prev_valid = out_valid;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0;
        in_valid = 1'b0;
        in_i = '0;
        in_q = '0;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R1 reset state", int'(out_valid), 0);
        rst_n = 1'b1;
        repeat (5) idle_cycle();
        chk(out_valid == 1'b0, "R1 quiet after reset", int'(out_valid), 0);

        // Partial frame (tag 15), then reset mid-frame.
        send(15, 500, 20, 1'b0);
        repeat (20) idle_cycle();
        chk(out_valid == 1'b0, "R8 partial frame", int'(out_valid), 0);
        rst_n = 1'b0;
        idle_cycle();
        chk(out_valid == 1'b0, "R9 reset mid-frame", int'(out_valid), 0);
        rst_n = 1'b1;

        // Frame 0: gaps, long pause before the final sample.
        send(0, NPT, 40, 1'b1);
        repeat (1100) idle_cycle();
        chk(fr_out == 1, "R4 frame 0 emitted", fr_out, 1);

        // Frames 1..3 back to back, frame 4 with gaps during frame 3 drain.
        send(1, NPT, 0, 1'b0);
        send(2, NPT, 0, 1'b0);
        send(3, NPT, 0, 1'b0);
        send(4, NPT, 30, 1'b0);
        repeat (1100) idle_cycle();

        chk(fr_out == 5, "R4/R6 all frames emitted", fr_out, 5);
        chk(bb_seen >= 2, "R7 seamless frame boundaries", bb_seen, 2);
        chk(out_valid == 1'b0, "R8 idle after drain", int'(out_valid), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        chk(1'b0, "R4 watchdog expired", cyc, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule